// File: doc/BRIEF.md
# Dual-Port Synchronous Block Memory

This block is a true dual-port memory with two fully independent ports over one shared storage array. Each port has its own clock, asynchronous active-low reset, enable, write-enable, address and data. The ports may differ in width: port A moves whole wide words and port B moves narrow sub-words of those same words. By default these are 16-bit words and 4-bit sub-words.

Every port input is sampled on the rising edge of that port's clock, and each data output comes from a register. There is therefore no combinational path from an address pin to a data pin. An enabled read loads the addressed contents into the port's output register on that edge. An enabled write stores the data and also shows the written value on the same port's output. Otherwise the output keeps its value, whatever happens on the other port or on this port's unclocked inputs.

The ports are not arbitrated against each other. Two writes to the same word on coinciding edges leave that word undefined. Users must avoid this case.

Top module: `dpram_dual`

## Requirements
- R1: While a port's reset input is low, that port's output is zero. The internal release of the port's reset happens at least one rising edge of that port's clock after the reset input goes high.
- R2: A read is en=1, we=0 at a rising edge. After that edge, the port's output equals the contents of the address sampled on that edge, and it keeps that value until the port's next enabled edge.
- R3: A write is en=1, we=1 at a rising edge. After that edge, the port's own output equals the data sampled on that edge, and the storage holds that data at that address.
- R4: With en=0, an edge changes neither the port's output nor the storage, even when we=1.
- R5: Changes on address or data between edges, or at edges with en=0, never reach the output. Only an enabled edge of the port alters its output.
- R6: A write on one port never changes the other port's output, even when both refer to the same location. The new contents appear there only after that port performs its own enabled read.
- R7: The port B address is the wide-word index followed by log2(A_W/B_W) sub-word select bits in the least-significant positions. Select value 0 addresses bits [B_W-1:0] of the wide word, and higher select values address successively higher sub-words.
- R8: A port B write changes only its own sub-word, and the other sub-words of that wide word keep their contents. A port A write updates every sub-word seen by port B.
- R9: The two ports work correctly with unrelated clock periods while both are active on different words at the same time.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_a | input | 1 | Port A clock |
| rst_a_n | input | 1 | Port A asynchronous reset, active low |
| en_a | input | 1 | Port A operation enable |
| we_a | input | 1 | Port A write select (1 = write, 0 = read) |
| addr_a | input | $clog2(A_DEPTH) | Port A wide-word address |
| din_a | input | A_W | Port A write data |
| dout_a | output | A_W | Port A registered output |
| clk_b | input | 1 | Port B clock |
| rst_b_n | input | 1 | Port B asynchronous reset, active low |
| en_b | input | 1 | Port B operation enable |
| we_b | input | 1 | Port B write select (1 = write, 0 = read) |
| addr_b | input | $clog2(A_DEPTH*A_W/B_W) | Port B sub-word address |
| din_b | input | B_W | Port B write data |
| dout_b | output | B_W | Port B registered output |

## Verification
Reads and writes both take effect one edge after they are issued. A value driven before rising edge N of a port's clock is visible on that port's output at the falling edge that follows edge N. The bench drives inputs and compares outputs only on falling edges, so each comparison at a falling edge is set against a reference updated at the preceding rising edge of the same port. The rising edges of the two clocks are placed so they never coincide, which keeps the order of the two ports' updates in the reference model well defined. Idle stretches are compared on every cycle as well, so the hold behaviour and the absence of cross-port forwarding are seen cycle by cycle.

// File: rtl/dpram_pkg.sv
package dpram_pkg;

  typedef enum logic [1:0] {
    OP_NONE  = 2'd0,
    OP_READ  = 2'd1,
    OP_WRITE = 2'd2
  } port_op_e;

  function automatic port_op_e decode_op(input logic active, input logic en, input logic we);
    if (!(active && en)) return OP_NONE;
    return we ? OP_WRITE : OP_READ;
  endfunction

endpackage

// File: rtl/dpram_rst_sync.sv
module dpram_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic rst_n_o
);

  logic [STAGES-1:0] chain_d;
  logic [STAGES-1:0] chain_q;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) chain_q <= '0;
    else         chain_q <= chain_d;
  end

  assign rst_n_o = chain_q[STAGES-1];

  // R1: internal release only after the external reset was seen high on an earlier edge
  p_release_after_input_r1: assert property (@(posedge clk) disable iff (!arst_n)
    $rose(rst_n_o) |-> $past(arst_n));

endmodule

// File: rtl/dpram_store.sv
module dpram_store #(
  parameter int WIDE_W     = 16,
  parameter int NARROW_W   = 4,
  parameter int WIDE_DEPTH = 64,
  localparam int RATIO     = WIDE_W / NARROW_W,
  localparam int SEL_W     = $clog2(RATIO),
  localparam int WA_W      = $clog2(WIDE_DEPTH),
  localparam int NA_W      = WA_W + SEL_W,
  localparam int N_DEPTH   = WIDE_DEPTH * RATIO
) (
  input  logic                clk_a,
  input  logic                wr_a,
  input  logic [WA_W-1:0]     addr_a,
  input  logic [WIDE_W-1:0]   din_a,
  output logic [WIDE_W-1:0]   rd_a,
  input  logic                clk_b,
  input  logic                wr_b,
  input  logic [NA_W-1:0]     addr_b,
  input  logic [NARROW_W-1:0] din_b,
  output logic [NARROW_W-1:0] rd_b
);

  // Each bank has exactly one writer; a location's value is the XOR of both banks.
  logic [WIDE_W-1:0]   bank_w [WIDE_DEPTH];
  logic [NARROW_W-1:0] bank_n [N_DEPTH];

  logic [WIDE_W-1:0]   narrow_view_a;
  logic [WA_W-1:0]     word_b;
  logic [SEL_W-1:0]    sel_b;
  logic [WIDE_W-1:0]   wide_word_b;
  logic [NARROW_W-1:0] wide_view_b;

  for (genvar s = 0; s < RATIO; s++) begin : g_sub
    assign narrow_view_a[s*NARROW_W +: NARROW_W] = bank_n[{addr_a, SEL_W'(s)}];
  end

  always_comb begin
    word_b      = addr_b[NA_W-1:SEL_W];
    sel_b       = addr_b[SEL_W-1:0];
    wide_word_b = bank_w[word_b];
    wide_view_b = wide_word_b[sel_b*NARROW_W +: NARROW_W];
    rd_a        = bank_w[addr_a] ^ narrow_view_a;
    rd_b        = bank_n[addr_b] ^ wide_view_b;
  end

  always_ff @(posedge clk_a) begin
    if (wr_a) bank_w[addr_a] <= din_a ^ narrow_view_a;
  end

  always_ff @(posedge clk_b) begin
    if (wr_b) bank_n[addr_b] <= din_b ^ wide_view_b;
  end

endmodule

// File: rtl/dpram_port.sv
module dpram_port
  import dpram_pkg::*;
#(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         en,
  input  logic         we,
  input  logic [W-1:0] din,
  input  logic [W-1:0] rdata,
  output logic         wr_o,
  output logic [W-1:0] dout
);

  port_op_e     op;
  logic         load;
  logic [W-1:0] dout_d;
  logic [W-1:0] dout_q;

  always_comb begin
    op     = decode_op(rst_n, en, we);
    load   = 1'b0;
    dout_d = dout_q;
    case (op)
      OP_READ:  begin load = 1'b1; dout_d = rdata; end
      OP_WRITE: begin load = 1'b1; dout_d = din;   end
      default:  begin load = 1'b0; dout_d = dout_q; end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    dout_q <= '0;
    else if (load) dout_q <= dout_d;
  end

  assign wr_o = (op == OP_WRITE);
  assign dout = dout_q;

  p_write_echo_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (en && we) |=> (dout == $past(din)));

  p_idle_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> $stable(dout));

  p_change_needs_enable_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (dout != $past(dout)) |-> $past(en));

endmodule

// File: rtl/dpram_dual.sv
module dpram_dual #(
  parameter int A_W     = 16,
  parameter int B_W     = 4,
  parameter int A_DEPTH = 64
) (
  input  logic                                  clk_a,
  input  logic                                  rst_a_n,
  input  logic                                  en_a,
  input  logic                                  we_a,
  input  logic [$clog2(A_DEPTH)-1:0]            addr_a,
  input  logic [A_W-1:0]                        din_a,
  output logic [A_W-1:0]                        dout_a,
  input  logic                                  clk_b,
  input  logic                                  rst_b_n,
  input  logic                                  en_b,
  input  logic                                  we_b,
  input  logic [$clog2(A_DEPTH*(A_W/B_W))-1:0]  addr_b,
  input  logic [B_W-1:0]                        din_b,
  output logic [B_W-1:0]                        dout_b
);

  localparam int SYNC_STAGES = 2;

  logic          rst_a_s_n;
  logic          rst_b_s_n;
  logic          wr_a;
  logic          wr_b;
  logic [A_W-1:0] rd_a;
  logic [B_W-1:0] rd_b;

  dpram_rst_sync #(.STAGES(SYNC_STAGES)) u_rst_a (
    .clk(clk_a), .arst_n(rst_a_n), .rst_n_o(rst_a_s_n));

  dpram_rst_sync #(.STAGES(SYNC_STAGES)) u_rst_b (
    .clk(clk_b), .arst_n(rst_b_n), .rst_n_o(rst_b_s_n));

  dpram_store #(.WIDE_W(A_W), .NARROW_W(B_W), .WIDE_DEPTH(A_DEPTH)) u_store (
    .clk_a(clk_a), .wr_a(wr_a), .addr_a(addr_a), .din_a(din_a), .rd_a(rd_a),
    .clk_b(clk_b), .wr_b(wr_b), .addr_b(addr_b), .din_b(din_b), .rd_b(rd_b));

  dpram_port #(.W(A_W)) u_port_a (
    .clk(clk_a), .rst_n(rst_a_s_n), .en(en_a), .we(we_a),
    .din(din_a), .rdata(rd_a), .wr_o(wr_a), .dout(dout_a));

  dpram_port #(.W(B_W)) u_port_b (
    .clk(clk_b), .rst_n(rst_b_s_n), .en(en_b), .we(we_b),
    .din(din_b), .rdata(rd_b), .wr_o(wr_b), .dout(dout_b));

endmodule

// File: tb/sim_dpram_dual.sv
module sim_dpram_dual;

  localparam int A_W     = 16;
  localparam int B_W     = 4;
  localparam int A_DEPTH = 64;
  localparam int RATIO   = A_W / B_W;
  localparam int AA_W    = $clog2(A_DEPTH);
  localparam int BA_W    = $clog2(A_DEPTH * RATIO);
  localparam int B_DEPTH = A_DEPTH * RATIO;

  logic clk_a, clk_b, rst_a_n, rst_b_n;
  logic en_a, we_a, en_b, we_b;
  logic [AA_W-1:0] addr_a;
  logic [BA_W-1:0] addr_b;
  logic [A_W-1:0]  din_a, dout_a;
  logic [B_W-1:0]  din_b, dout_b;

  int checks = 0;
  int errors = 0;
  bit done = 0;
  int cyc = 0;
  string tag_a = "R1", tag_b = "R1", tag_qa = "R1", tag_qb = "R1";

  dpram_dual #(.A_W(A_W), .B_W(B_W), .A_DEPTH(A_DEPTH)) u0 (
    .clk_a(clk_a), .rst_a_n(rst_a_n), .en_a(en_a), .we_a(we_a), .addr_a(addr_a),
    .din_a(din_a), .dout_a(dout_a),
    .clk_b(clk_b), .rst_b_n(rst_b_n), .en_b(en_b), .we_b(we_b), .addr_b(addr_b),
    .din_b(din_b), .dout_b(dout_b));

  // Port A: 100 MHz, rising edges at 5 + 10k ns. Port B: rising edges at 2 + 14k ns (never coincide).
  initial begin
    clk_a = 1'b0;
    forever #5 clk_a = ~clk_a;
  end
  initial begin
    clk_b = 1'b0;
    #2;
    forever begin clk_b = 1'b1; #7; clk_b = 1'b0; #7; end
  end
  always @(posedge clk_a) cyc++;

  // Reference model: narrow cell array, expected outputs, updated on each port's rising edge.
  logic [B_W-1:0] ref_mem [B_DEPTH];
  logic [A_W-1:0] exp_a;
  logic [B_W-1:0] exp_b;
  logic la = 1'b0, lb = 1'b0;

  always @(clk_a or clk_b) begin
    if (clk_a && !la) begin
      tag_qa = tag_a;
      if (!rst_a_n) exp_a = '0;
      else if (en_a) begin
        for (int s = 0; s < RATIO; s++) begin
          if (we_a) ref_mem[int'(addr_a)*RATIO + s] = din_a[s*B_W +: B_W];
          exp_a[s*B_W +: B_W] = ref_mem[int'(addr_a)*RATIO + s];
        end
      end
    end
    if (clk_b && !lb) begin
      tag_qb = tag_b;
      if (!rst_b_n) exp_b = '0;
      else if (en_b) begin
        if (we_b) ref_mem[addr_b] = din_b;
        exp_b = ref_mem[addr_b];
      end
    end
    la = clk_a;
    lb = clk_b;
  end

  task automatic check(input string tag, input logic ok, input logic [A_W-1:0] act,
                       input logic [A_W-1:0] expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h at %0t", tag, act, expv, $time);
    end
  endtask

  always @(negedge clk_a) if (!done) begin
    logic [A_W-1:0] e;
    e = rst_a_n ? exp_a : '0;
    check({tag_qa, " port A"}, dout_a === e, dout_a, e);
  end
  always @(negedge clk_b) if (!done) begin
    logic [B_W-1:0] e;
    e = rst_b_n ? exp_b : '0;
    check({tag_qb, " port B"}, dout_b === e, A_W'(dout_b), A_W'(e));
  end

  task automatic a_op(input logic e, input logic w, input int ad, input logic [A_W-1:0] d);
    @(negedge clk_a);
    en_a = e; we_a = w; addr_a = AA_W'(ad); din_a = d;
  endtask
  task automatic b_op(input logic e, input logic w, input int ad, input logic [B_W-1:0] d);
    @(negedge clk_b);
    en_b = e; we_b = w; addr_b = BA_W'(ad); din_b = d;
  endtask

  function automatic logic [A_W-1:0] fill(input int i);
    return A_W'(i * 16'h0123) ^ 16'hA5C3;
  endfunction

  initial begin
    rst_a_n = 1'b1; rst_b_n = 1'b1;
    en_a = 0; we_a = 0; addr_a = '0; din_a = '0;
    en_b = 0; we_b = 0; addr_b = '0; din_b = '0;
    #1 rst_a_n = 1'b0; rst_b_n = 1'b0;
    // R1: outputs are zero during reset
    repeat (3) @(negedge clk_a);
    check("R1 reset A", dout_a === '0, dout_a, '0);
    check("R1 reset B", dout_b === '0, A_W'(dout_b), '0);
    rst_a_n = 1'b1; rst_b_n = 1'b1;
    repeat (5) a_op(0, 0, 0, '0);
    repeat (3) b_op(0, 0, 0, '0);

    // R3: fill every word through port A; each write echoes on dout_a
    tag_a = "R3";
    for (int i = 0; i < A_DEPTH; i++) a_op(1, 1, i, fill(i));
    a_op(0, 0, 0, '0);
    check("R3 echo of last write", dout_a === fill(A_DEPTH-1), dout_a, fill(A_DEPTH-1));

    // R2: read back several words one edge after issue
    tag_a = "R2";
    for (int i = 0; i < 8; i++) a_op(1, 0, i * 7, '0);
    a_op(0, 0, 0, '0);
    check("R2 read word 49", dout_a === fill(49), dout_a, fill(49));

    // R4: disabled write changes neither output nor storage
    tag_a = "R4";
    a_op(0, 1, 3, 16'hDEAD);
    a_op(0, 1, 3, 16'hBEEF);
    a_op(1, 0, 3, '0);
    a_op(0, 0, 0, '0);
    check("R4 word 3 untouched", dout_a === fill(3), dout_a, fill(3));

    // R5: address and data wander with en low; output holds
    tag_a = "R5";
    a_op(1, 0, 1, '0);
    for (int i = 0; i < 6; i++) a_op(0, i[0], 10 + i, 16'h1111 * i);
    check("R5 hold after wander", dout_a === fill(1), dout_a, fill(1));

    // R7: sub-word order, select 0 = least significant nibble
    tag_a = "R7"; tag_b = "R7";
    a_op(1, 1, 2, 16'h4321);
    a_op(0, 0, 0, '0);
    for (int s = 0; s < RATIO; s++) begin
      b_op(1, 0, 2 * RATIO + s, '0);
      b_op(0, 0, 0, '0);
      check("R7 sub-word select", dout_b === B_W'(s + 1), A_W'(dout_b), A_W'(s + 1));
    end

    // R3 on port B: write echo on the narrow port
    tag_b = "R3";
    b_op(1, 1, 100, 4'h9);
    b_op(0, 0, 0, '0);
    check("R3 B echo", dout_b === 4'h9, A_W'(dout_b), 16'h9);

    // R8: narrow write changes only its sub-word
    tag_b = "R8"; tag_a = "R8";
    b_op(1, 1, 5 * RATIO + 1, 4'hC);
    b_op(0, 0, 0, '0);
    a_op(1, 0, 5, '0);
    a_op(0, 0, 0, '0);
    check("R8 partial update", dout_a === {fill(5)[15:8], 4'hC, fill(5)[3:0]},
          dout_a, {fill(5)[15:8], 4'hC, fill(5)[3:0]});

    // R6: other-port write to the word port A just read; A holds until it reads again
    tag_a = "R6"; tag_b = "R6";
    a_op(1, 0, 6, '0);
    a_op(0, 0, 0, '0);
    b_op(1, 1, 6 * RATIO, 4'h0);
    b_op(0, 0, 0, '0);
    repeat (3) a_op(0, 0, 6, '0);
    check("R6 no forwarding to A", dout_a === fill(6), dout_a, fill(6));
    a_op(1, 0, 6, '0);
    a_op(0, 0, 0, '0);
    check("R6 refresh after read", dout_a === {fill(6)[15:4], 4'h0}, dout_a, {fill(6)[15:4], 4'h0});
    b_op(1, 0, 7 * RATIO + 3, '0);
    b_op(0, 0, 0, '0);
    a_op(1, 1, 7, 16'h0F0F);
    a_op(0, 0, 0, '0);
    repeat (2) b_op(0, 0, 7 * RATIO + 3, '0);
    check("R6 no forwarding to B", dout_b === fill(7)[15:12], A_W'(dout_b), A_W'(fill(7)[15:12]));

    // R9: both ports busy at once on different words with unrelated clocks
    tag_a = "R9"; tag_b = "R9";
    fork
      begin
        for (int i = 0; i < 10; i++) a_op(1, 1, 20 + i, 16'hA000 + 16'h0111 * i);
        for (int i = 0; i < 10; i++) a_op(1, 0, 40 + i, '0);
        a_op(0, 0, 0, '0);
      end
      begin
        for (int i = 0; i < 10; i++) b_op(1, 1, (40 + i) * RATIO + (i % RATIO), B_W'(i + 3));
        for (int i = 0; i < 10; i++) b_op(1, 0, (20 + i) * RATIO + 2, '0);
        b_op(0, 0, 0, '0);
      end
    join
    repeat (2) a_op(0, 0, 0, '0);
    repeat (2) b_op(0, 0, 0, '0);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #200000;
    if (!done) begin
      errors++;
      $display("FAIL R9 watchdog: cycles %0d expected completion before %0d", cyc, 20000);
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule